// File: doc/BRIEF.md
# PHY Power-State Controller

This block is the state machine on the PHY side of a synchronous MAC-to-PHY link. It tracks the power and activity state of the PHY. The MAC drives three inputs: a reset request and two enables, one for transmit and one for receive. A two-bit power-mode field arrives as a plain input, and a single-cycle completion pulse comes from the PHY core when its reset work ends. The block answers on one activity line. That line reports reset in progress, the wake handshake and an ongoing transmit or receive. The block also drives the state code, a clock enable for the link clock, a ready level and a gated clear-channel-assessment report.

The same three wires, the two enables and the activity line, carry both the reset and wake handshakes and the normal frame activity. The meaning of each combination depends on the current state. The state machine holds that context. The power-mode field picks the resting state whenever no handshake or frame is in progress.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: A high `phy_reset_i` sampled at a clock edge puts the state into RESET at that edge, whatever the state and the other inputs. State codes on `state_o`: RESET=0, SLEEP=1, STANDBY=2, READY=3, TRANSMIT=4, RECEIVE=5.
- R2: In RESET, `phy_active_o` is high and `pclk_en_o` is low. RESET is also the state right after `rst_n` is released.
- R3: A `reset_done_i` pulse sampled in RESET while `phy_reset_i` is low moves the state to STANDBY with `phy_active_o` low at the same edge. A pulse that arrives while `phy_reset_i` is high is ignored.
- R4: In SLEEP, `pclk_en_o` is low. Both enables high together move the state to STANDBY with `phy_active_o` high. A single enable alone leaves the state in SLEEP.
- R5: After a wake, `phy_active_o` stays high in STANDBY until both enables are seen low, and it falls at that edge. While the handshake is pending, `pm_mode_i` is ignored.
- R6: `pm_mode_i` selects the resting state: 2'b00 READY, 2'b01 STANDBY, 2'b10 SLEEP, 2'b11 reserved (the state is held). It acts one edge later, from STANDBY, and from READY when both enables are low.
- R7: From READY, `tx_en_i` alone enters TRANSMIT and `rx_en_i` alone enters RECEIVE, with `phy_active_o` high. Both enables high together leave READY unchanged. `pm_mode_i` has no effect in TRANSMIT or RECEIVE.
- R8: When the enable of the current activity drops, the first edge releases `phy_active_o` and holds the state. The following edge returns the state to READY.
- R9: `ready_o` is high exactly when the state is STANDBY, READY, TRANSMIT or RECEIVE and `phy_reset_i` is low. It follows `phy_reset_i` in the same cycle.
- R10: `cca_report_o` rises after `cca_en_i` has been sampled high at CCA_VALID_CYCLES consecutive edges. It is shown only in READY or RECEIVE. Dropping `cca_en_i` restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| phy_reset_i | input | 1 | Reset request from the MAC |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rx_en_i | input | 1 | Receive enable from the MAC |
| pm_mode_i | input | 2 | Power-mode field from the register file |
| reset_done_i | input | 1 | One-cycle pulse from the PHY core when its reset work is finished |
| cca_en_i | input | 1 | Clear-channel-assessment enable bit |
| phy_active_o | output | 1 | Activity and handshake line to the MAC |
| state_o | output | 3 | Current state code |
| pclk_en_o | output | 1 | Clock enable for the link clock |
| ready_o | output | 1 | Ready status level |
| cca_report_o | output | 1 | Gated clear-channel-assessment report |

## Verification
The collisions that matter are a reset request in the same cycle as another event. One is a reset request together with a transmit entry from READY. The other is a reset request together with the reset-completion pulse. The bench raises both inputs before one edge. It then checks that the state is RESET, that the activity line is high and that the ready level dropped in the same cycle as the request. A second collision places a power-mode change in the same cycle as a pending wake handshake or an active transmit. The check confirms that the state does not move until the handshake or the frame tail has finished.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_STANDBY = 3'd2,
    ST_READY   = 3'd3,
    ST_TX      = 3'd4,
    ST_RX      = 3'd5
  } pwr_state_t;

  // resting state chosen by the power-mode field; reserved code keeps cur
  function automatic pwr_state_t pm_target(input pwr_state_t cur, input logic [1:0] pm);
    case (pm)
      2'b00:   pm_target = ST_READY;
      2'b01:   pm_target = ST_STANDBY;
      2'b10:   pm_target = ST_SLEEP;
      default: pm_target = cur;
    endcase
  endfunction

  function automatic logic clock_on(input pwr_state_t s);
    clock_on = (s != ST_SLEEP) && (s != ST_RESET);
  endfunction

  function automatic logic cca_allowed(input pwr_state_t s);
    cca_allowed = (s == ST_READY) || (s == ST_RX);
  endfunction

  function automatic logic operational(input pwr_state_t s);
    operational = (s == ST_STANDBY) || (s == ST_READY) || (s == ST_TX) || (s == ST_RX);
  endfunction

endpackage

// File: rtl/phy_pwr_fsm.sv
module phy_pwr_fsm
  import phy_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phy_reset_i,
  input  logic       tx_en_i,
  input  logic       rx_en_i,
  input  logic [1:0] pm_mode_i,
  input  logic       reset_done_i,
  output pwr_state_t state_o,
  output logic       phy_active_o
);

  pwr_state_t st, st_nxt;
  logic wake_q, wake_n;  // wake handshake pending in STANDBY
  logic act_q, act_n;    // frame activity in TRANSMIT / RECEIVE

  // named internal events
  logic ev_wake_req, ev_done_ok, ev_tail_tx, ev_tail_rx;
  assign ev_wake_req = (st == ST_SLEEP) && tx_en_i && rx_en_i && !phy_reset_i;
  assign ev_done_ok  = (st == ST_RESET) && reset_done_i && !phy_reset_i;
  assign ev_tail_tx  = (st == ST_TX) && act_q && !tx_en_i && !phy_reset_i;
  assign ev_tail_rx  = (st == ST_RX) && act_q && !rx_en_i && !phy_reset_i;

  always_comb begin
    st_nxt = st;
    wake_n = wake_q;
    act_n  = act_q;
    if (phy_reset_i) begin
      st_nxt = ST_RESET;
      wake_n = 1'b0;
      act_n  = 1'b0;
    end else begin
      case (st)
        ST_RESET: if (reset_done_i) st_nxt = ST_STANDBY;
        ST_SLEEP: begin
          if (tx_en_i && rx_en_i) begin
            st_nxt = ST_STANDBY;
            wake_n = 1'b1;
          end
        end
        ST_STANDBY: begin
          if (wake_q) begin
            if (!tx_en_i && !rx_en_i) wake_n = 1'b0;
          end else begin
            st_nxt = pm_target(st, pm_mode_i);
          end
        end
        ST_READY: begin
          if (tx_en_i ^ rx_en_i) begin
            st_nxt = tx_en_i ? ST_TX : ST_RX;
            act_n  = 1'b1;
          end else if (!tx_en_i && !rx_en_i) begin
            st_nxt = pm_target(st, pm_mode_i);
          end
        end
        ST_TX: begin
          if (!tx_en_i) begin
            if (act_q) act_n = 1'b0;
            else       st_nxt = ST_READY;
          end
        end
        ST_RX: begin
          if (!rx_en_i) begin
            if (act_q) act_n = 1'b0;
            else       st_nxt = ST_READY;
          end
        end
        default: st_nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_RESET;
      wake_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      st     <= st_nxt;
      wake_q <= wake_n;
      act_q  <= act_n;
    end
  end

  assign state_o      = st;
  assign phy_active_o = (st == ST_RESET) || wake_q || act_q;

  p_reset_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phy_reset_i |=> (st == ST_RESET));

  p_done_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done_ok |=> (st == ST_STANDBY) && !phy_active_o);

  p_wake_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake_req |=> (st == ST_STANDBY) && phy_active_o);

  p_tx_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tail_tx |=> (st == ST_TX) && !phy_active_o);

  p_rx_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tail_rx |=> (st == ST_RX) && !phy_active_o);

endmodule

// File: rtl/phy_cca_gate.sv
module phy_cca_gate #(
  parameter int unsigned VALID_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic allowed_i,
  output logic report_o
);

  localparam int unsigned CW = $clog2(VALID_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(VALID_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!enable_i)    cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign settled  = (cnt_q == LIMIT);
  assign report_o = enable_i && settled && allowed_i;

  p_cca_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !report_o);

endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
  import phy_pwr_pkg::*;
#(
  parameter int unsigned CCA_VALID_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phy_reset_i,
  input  logic       tx_en_i,
  input  logic       rx_en_i,
  input  logic [1:0] pm_mode_i,
  input  logic       reset_done_i,
  input  logic       cca_en_i,
  output logic       phy_active_o,
  output logic [2:0] state_o,
  output logic       pclk_en_o,
  output logic       ready_o,
  output logic       cca_report_o
);

  pwr_state_t cur_state;
  logic       cca_window;

  phy_pwr_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .phy_reset_i  (phy_reset_i),
    .tx_en_i      (tx_en_i),
    .rx_en_i      (rx_en_i),
    .pm_mode_i    (pm_mode_i),
    .reset_done_i (reset_done_i),
    .state_o      (cur_state),
    .phy_active_o (phy_active_o)
  );

  assign cca_window = cca_allowed(cur_state);

  phy_cca_gate #(.VALID_CYCLES(CCA_VALID_CYCLES)) u_cca (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (cca_en_i),
    .allowed_i (cca_window),
    .report_o  (cca_report_o)
  );

  assign state_o   = cur_state;
  assign pclk_en_o = clock_on(cur_state);
  assign ready_o   = operational(cur_state) && !phy_reset_i;

  p_reset_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> (phy_active_o && !pclk_en_o));

  p_sleep_clock_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |-> !pclk_en_o);

  p_cca_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cca_report_o |-> (state_o == 3'd3 || state_o == 3'd5));

  p_ready_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phy_reset_i |-> !ready_o);

endmodule

// File: tb/sim_phy_pwr_ctrl.sv
module sim_phy_pwr_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phy_reset_i = 1'b0;
  logic       tx_en_i = 1'b0;
  logic       rx_en_i = 1'b0;
  logic [1:0] pm_mode_i = 2'b11;
  logic       reset_done_i = 1'b0;
  logic       cca_en_i = 1'b0;
  logic       phy_active_o, pclk_en_o, ready_o, cca_report_o;
  logic [2:0] state_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  localparam logic [2:0] S_RST = 3'd0, S_SLP = 3'd1, S_STB = 3'd2,
                         S_RDY = 3'd3, S_TX = 3'd4, S_RX = 3'd5;

  always #2.5 clk = ~clk;

  phy_pwr_ctrl #(.CCA_VALID_CYCLES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .phy_reset_i(phy_reset_i), .tx_en_i(tx_en_i),
    .rx_en_i(rx_en_i), .pm_mode_i(pm_mode_i), .reset_done_i(reset_done_i),
    .cca_en_i(cca_en_i), .phy_active_o(phy_active_o), .state_o(state_o),
    .pclk_en_o(pclk_en_o), .ready_o(ready_o), .cca_report_o(cca_report_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one rising edge, sampled at the following falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R2 state", state_o, S_RST);
    chk("R2 active", phy_active_o, 1);
    chk("R2 pclk", pclk_en_o, 0);
    chk("R9 ready", ready_o, 0);
    chk("R10 cca", cca_report_o, 0);
  endtask

  task automatic t_done_vs_reset();
    phy_reset_i = 1; reset_done_i = 1; tick();
    chk("R3 done ignored while reset held", state_o, S_RST);
    chk("R2 active in reset", phy_active_o, 1);
    phy_reset_i = 0; tick();
    reset_done_i = 0;
    chk("R3 state", state_o, S_STB);
    chk("R3 active released", phy_active_o, 0);
    chk("R9 ready in standby", ready_o, 1);
    chk("R2 pclk on after reset", pclk_en_o, 1);
  endtask

  task automatic t_pm_modes();
    pm_mode_i = 2'b00; tick();
    chk("R6 to READY", state_o, S_RDY);
    pm_mode_i = 2'b11; tick();
    chk("R6 reserved holds", state_o, S_RDY);
    pm_mode_i = 2'b01; tick();
    chk("R6 to STANDBY", state_o, S_STB);
    pm_mode_i = 2'b10; tick();
    chk("R6 to SLEEP", state_o, S_SLP);
    chk("R4 pclk off", pclk_en_o, 0);
    chk("R9 ready in sleep", ready_o, 0);
    tx_en_i = 1; tick();
    chk("R4 single enable ignored", state_o, S_SLP);
    tx_en_i = 0;
  endtask

  task automatic t_wake();
    tx_en_i = 1; rx_en_i = 1; pm_mode_i = 2'b00; tick();
    chk("R4 wake state", state_o, S_STB);
    chk("R4 wake active", phy_active_o, 1);
    tick();
    chk("R5 pm ignored while pending", state_o, S_STB);
    tx_en_i = 0; tick();
    chk("R5 active held with one enable", phy_active_o, 1);
    rx_en_i = 0; tick();
    chk("R5 active dropped", phy_active_o, 0);
    chk("R5 state after handshake", state_o, S_STB);
    tick();
    chk("R6 mode applies after handshake", state_o, S_RDY);
  endtask

  task automatic t_tx();
    tx_en_i = 1; tick();
    chk("R7 TRANSMIT entry", state_o, S_TX);
    chk("R7 active in tx", phy_active_o, 1);
    pm_mode_i = 2'b10; tick();
    chk("R7 pm ignored in tx", state_o, S_TX);
    pm_mode_i = 2'b00;
    tx_en_i = 0; tick();
    chk("R8 tx tail state", state_o, S_TX);
    chk("R8 tx tail active", phy_active_o, 0);
    tick();
    chk("R8 back to READY", state_o, S_RDY);
  endtask

  task automatic t_rx();
    rx_en_i = 1; tick();
    chk("R7 RECEIVE entry", state_o, S_RX);
    chk("R7 active in rx", phy_active_o, 1);
    rx_en_i = 0; tick();
    chk("R8 rx tail active", phy_active_o, 0);
    chk("R8 rx tail state", state_o, S_RX);
    tick();
    chk("R8 rx back to READY", state_o, S_RDY);
    tx_en_i = 1; rx_en_i = 1; tick();
    chk("R7 both enables hold READY", state_o, S_RDY);
    tx_en_i = 0; rx_en_i = 0; tick();
  endtask

  task automatic t_cca();
    cca_en_i = 1;
    for (int i = 0; i < 3; i++) tick();
    chk("R10 not yet valid", cca_report_o, 0);
    tick();
    chk("R10 valid after window", cca_report_o, 1);
    tx_en_i = 1; tick();
    chk("R10 suppressed in tx", cca_report_o, 0);
    tx_en_i = 0; tick(); tick();
    chk("R10 shown again in READY", cca_report_o, 1);
    cca_en_i = 0; tick();
    chk("R10 off when disabled", cca_report_o, 0);
    cca_en_i = 1; tick();
    chk("R10 count restarted", cca_report_o, 0);
    cca_en_i = 0; tick();
  endtask

  task automatic t_reset_collision();
    tx_en_i = 1; phy_reset_i = 1; #1;
    chk("R9 ready follows reset request", ready_o, 0);
    tick();
    chk("R1 reset beats tx entry", state_o, S_RST);
    chk("R1 active in reset", phy_active_o, 1);
    tx_en_i = 0; phy_reset_i = 0; reset_done_i = 1; tick();
    reset_done_i = 0;
    chk("R3 standby again", state_o, S_STB);
    pm_mode_i = 2'b10; tick();
    chk("R6 sleep", state_o, S_SLP);
    phy_reset_i = 1; tick();
    chk("R1 reset from sleep", state_o, S_RST);
    phy_reset_i = 0; tick();
    chk("R3 no pulse stays in reset", state_o, S_RST);
  endtask

  initial begin
    #200000;
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset_state();
    t_done_vs_reset();
    t_pm_modes();
    t_wake();
    t_tx();
    t_rx();
    t_cca();
    t_reset_collision();
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule